// File: doc/BRIEF.md
# Touch ADC SPI Scan Sequencer

This block is the SPI master for an eight-input serial touch-screen converter. A pulse on `start_i` captures an 8-bit channel mask. The block then visits every enabled channel, lowest index first. It holds chip select low for the whole scan and runs the channels' frame groups back to back.

Each channel gets a group of 24-bit frames. A frame carries an 8-bit command and then returns 16 reply bits. The first frames of a group give the analog input time to settle, so their results are thrown away. The remaining frames are oversamples. The block extracts the 12-bit result from each oversample reply and reports the rounded-up mean of those results. Each result comes out with a one-cycle strobe and the channel index.

The settling time in nanoseconds and the oversampling ratio are inputs, given separately for each channel. The integrator usually ties them to 1000 ns and 1. A further flag selects the converter's internal reference.

Top module: `touch_scan_seq`

## Requirements
- R1: Command byte format:
  - bit 7 is 1, bits 6:4 carry the channel address, and bit 3 is 0.
  - Bit 2 (single-ended) is set only for channels 0, 2, 6 and 7.
  - Bit 1 (reference on) is set only for those channels, and only when `int_ref_i` was high at start.
- R2: Within a channel's group, every frame but the last has bit 0 (converter on) set. The last frame has bits 1 and 0 both clear.
- R3: Each frame is 24 SCLK periods in SPI mode 0:
  - SCLK idles low, and MOSI changes only while SCLK is low.
  - The command goes out MSB first, and MISO is sampled on rising edges.
  - The result is bits 14:3 of the last 16 bits received. Bit 15 and bits 2:0 are ignored.
- R4: The settle frame count is ceil(ceil(settle_ns / B) / 24), where B = CLK_NS*SCLK_DIV ns (32 ns by default). The group length is that count plus the effective oversampling ratio.
- R5: The reported value is ceil(sum of the non-settle results / effective ratio). Settle-frame data has no effect on it.
- R6: Exactly one result is produced per enabled channel, in ascending index order. Each result is a single-cycle `res_valid_o` with `res_chan_o` giving the channel.
- R7: `cs_no` is high and `sclk_o` low out of reset and when idle. `cs_no` stays low without a break from the start of a scan until its end.
- R8: `done_o` is a one-cycle pulse that comes the cycle after the last result's strobe. With an empty mask, it comes the cycle after start is sampled, and no frame is sent.
- R9: A start pulse during a scan has no effect on the frames or results.
- R10: An oversampling ratio of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Scan start pulse |
| chan_mask_i | input | 8 | Channels to scan, captured at start |
| settle_ns_i | input | 8*SET_W | Per-channel settling time in ns, channel n at bits n*SET_W |
| ovs_ratio_i | input | 8*OVS_W | Per-channel oversampling ratio |
| int_ref_i | input | 1 | Use internal reference, captured at start |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to converter |
| miso_i | input | 1 | SPI data from converter |
| res_valid_o | output | 1 | Result strobe |
| res_chan_o | output | 3 | Channel index of result |
| res_data_o | output | 12 | Averaged result |
| done_o | output | 1 | Scan finished pulse |

## Verification
The scans cover a sparse mask at the default settling time, a mix of single-ended channels with the internal reference on, a full mask with no settling, and an empty mask.

- The modelled converter returns 0xFFF on every settle frame, so a result that included a settle frame would come out wrong. It also sets the reply bits that should be ignored, which tests the result extraction.
- The full-mask scan uses ratios from 0 to 15 with sums that do not divide evenly, which separates a ceiling mean from a truncating one.
- Settling times of 768 and 769 ns fall either side of an exact 24-bit boundary, and must give skip counts of 1 and 2.
- A second start pulse arrives part way through one scan.

// File: rtl/touch_scan_pkg.sv
package touch_scan_pkg;
  localparam int unsigned NCH        = 8;
  localparam int unsigned CH_W       = 3;
  localparam int unsigned CMD_W      = 8;
  localparam int unsigned RX_W       = 16;
  localparam int unsigned DATA_W     = 12;
  localparam int unsigned FRAME_BITS = CMD_W + RX_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_RUN, ST_RES, ST_FIN
  } scan_st_e;

  function automatic logic [CMD_W-1:0] mk_cmd(input logic [CH_W-1:0] ch,
                                              input logic last,
                                              input logic int_ref);
    logic se;
    se = (ch == 3'd0) || (ch == 3'd2) || (ch == 3'd6) || (ch == 3'd7);
    return {1'b1, ch, 1'b0, se, se & int_ref & ~last, ~last};
  endfunction
endpackage

// File: rtl/touch_spi_frame.sv
module touch_spi_frame import touch_scan_pkg::*; #(
  parameter int unsigned SCLK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic [RX_W-1:0]  rx_o
);
  localparam int unsigned HALF = SCLK_DIV / 2;
  localparam int unsigned HC_W = $clog2(HALF) + 1;

  logic                  active_q;
  logic [FRAME_BITS-1:0] tx_q;
  logic [RX_W-1:0]       rx_q;
  logic [4:0]            bit_q;
  logic [HC_W-1:0]       hc_q;
  logic                  sclk_q;
  logic                  done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
      bit_q    <= '0;
      hc_q     <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          tx_q     <= {cmd_i, {RX_W{1'b0}}};
          bit_q    <= '0;
          hc_q     <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (hc_q == HC_W'(HALF - 1)) begin
        hc_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[RX_W-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 5'(FRAME_BITS - 1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 5'd1;
            tx_q  <= {tx_q[FRAME_BITS-2:0], 1'b0};
          end
        end
      end else begin
        hc_q <= hc_q + HC_W'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[FRAME_BITS-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/touch_chan_cfg.sv
module touch_chan_cfg import touch_scan_pkg::*; #(
  parameter int unsigned SET_W  = 16,
  parameter int unsigned OVS_W  = 4,
  parameter int unsigned BIT_NS = 32,
  parameter int unsigned CNT_W  = 17
) (
  input  logic [NCH-1:0]       mask_i,
  input  logic [NCH*SET_W-1:0] settle_ns_i,
  input  logic [NCH*OVS_W-1:0] ovs_ratio_i,
  output logic [CH_W-1:0]      ch_o,
  output logic [NCH-1:0]       rest_o,
  output logic [CNT_W-1:0]     skip_o,
  output logic [CNT_W-1:0]     total_o,
  output logic [OVS_W-1:0]     ovs_o
);
  logic [SET_W-1:0] settle;
  logic [OVS_W-1:0] ovs;
  logic [31:0]      bits, skip;

  always_comb begin
    ch_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) ch_o = CH_W'(i);
    end
    rest_o       = mask_i;
    rest_o[ch_o] = 1'b0;
  end

  assign settle  = settle_ns_i[int'(ch_o)*SET_W +: SET_W];
  assign ovs     = ovs_ratio_i[int'(ch_o)*OVS_W +: OVS_W];
  assign ovs_o   = (ovs == '0) ? OVS_W'(1) : ovs;
  assign bits    = (32'(settle) + 32'(BIT_NS) - 32'd1) / 32'(BIT_NS);
  assign skip    = (bits + 32'(FRAME_BITS) - 32'd1) / 32'(FRAME_BITS);
  assign skip_o  = skip[CNT_W-1:0];
  assign total_o = skip_o + CNT_W'(ovs_o);
endmodule

// File: rtl/touch_avg.sv
module touch_avg import touch_scan_pkg::*; #(
  parameter int unsigned OVS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [OVS_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] avg_o
);
  localparam int unsigned ACC_W = DATA_W + OVS_W;

  logic [ACC_W-1:0] acc_q, num, quo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (add_i)  acc_q <= acc_q + ACC_W'(data_i);
  end

  assign num   = acc_q + ACC_W'(cnt_i) - ACC_W'(1);
  assign quo   = num / ACC_W'(cnt_i);
  assign avg_o = quo[DATA_W-1:0];
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq import touch_scan_pkg::*; #(
  parameter int unsigned CLK_NS   = 8,
  parameter int unsigned SCLK_DIV = 4,
  parameter int unsigned SET_W    = 16,
  parameter int unsigned OVS_W    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NCH-1:0]        chan_mask_i,
  input  logic [NCH*SET_W-1:0]  settle_ns_i,
  input  logic [NCH*OVS_W-1:0]  ovs_ratio_i,
  input  logic                  int_ref_i,
  output logic                  sclk_o,
  output logic                  cs_no,
  output logic                  mosi_o,
  input  logic                  miso_i,
  output logic                  res_valid_o,
  output logic [CH_W-1:0]       res_chan_o,
  output logic [DATA_W-1:0]     res_data_o,
  output logic                  done_o
);
  localparam int unsigned BIT_NS = CLK_NS * SCLK_DIV;
  localparam int unsigned CNT_W  = SET_W + 1;

  scan_st_e          st_q;
  logic [NCH-1:0]    pend_q, pick_rest;
  logic [CH_W-1:0]   ch_q, pick_ch;
  logic [CNT_W-1:0]  skip_q, total_q, idx_q, pick_skip, pick_total;
  logic [OVS_W-1:0]  ovs_q, pick_ovs;
  logic              ref_q, go_q, cs_n_q, valid_q, done_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [CH_W-1:0]   rchan_q;
  logic [DATA_W-1:0] rdata_q, avg;
  logic              frm_done;
  logic [RX_W-1:0]   frm_rx;
  logic              avg_clr, avg_add;

  touch_chan_cfg #(.SET_W(SET_W), .OVS_W(OVS_W), .BIT_NS(BIT_NS), .CNT_W(CNT_W)) cfg_i (
    .mask_i(pend_q), .settle_ns_i(settle_ns_i), .ovs_ratio_i(ovs_ratio_i),
    .ch_o(pick_ch), .rest_o(pick_rest), .skip_o(pick_skip),
    .total_o(pick_total), .ovs_o(pick_ovs)
  );

  touch_spi_frame #(.SCLK_DIV(SCLK_DIV)) frm_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_q), .cmd_i(cmd_q),
    .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .done_o(frm_done), .rx_o(frm_rx)
  );

  assign avg_clr = (st_q == ST_PICK);
  assign avg_add = (st_q == ST_RUN) && frm_done && (idx_q >= skip_q);

  touch_avg #(.OVS_W(OVS_W)) avg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(avg_clr), .add_i(avg_add),
    .data_i(frm_rx[14:3]), .cnt_i(ovs_q), .avg_o(avg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      ch_q    <= '0;
      skip_q  <= '0;
      total_q <= '0;
      idx_q   <= '0;
      ovs_q   <= OVS_W'(1);
      ref_q   <= 1'b0;
      go_q    <= 1'b0;
      cmd_q   <= '0;
      cs_n_q  <= 1'b1;
      valid_q <= 1'b0;
      rchan_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      go_q    <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (|chan_mask_i) begin
            pend_q <= chan_mask_i;
            ref_q  <= int_ref_i;
            cs_n_q <= 1'b0;
            st_q   <= ST_PICK;
          end else begin
            done_q <= 1'b1;
          end
        end
        ST_PICK: begin
          ch_q    <= pick_ch;
          skip_q  <= pick_skip;
          total_q <= pick_total;
          ovs_q   <= pick_ovs;
          pend_q  <= pick_rest;
          idx_q   <= '0;
          go_q    <= 1'b1;
          cmd_q   <= mk_cmd(pick_ch, pick_total == CNT_W'(1), ref_q);
          st_q    <= ST_RUN;
        end
        ST_RUN: if (frm_done) begin
          if (idx_q == total_q - CNT_W'(1)) begin
            st_q <= ST_RES;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
            go_q  <= 1'b1;
            cmd_q <= mk_cmd(ch_q, (idx_q + CNT_W'(2)) == total_q, ref_q);
          end
        end
        ST_RES: begin
          valid_q <= 1'b1;
          rchan_q <= ch_q;
          rdata_q <= avg;
          st_q    <= (|pend_q) ? ST_PICK : ST_FIN;
        end
        ST_FIN: begin
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no       = cs_n_q;
  assign res_valid_o = valid_q;
  assign res_chan_o  = rchan_q;
  assign res_data_o  = rdata_q;
  assign done_o      = done_q;
endmodule

// File: rtl/touch_scan_seq_chk.sv
module touch_scan_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o,
  input logic res_valid_o,
  input logic done_o
);
  AST_CS_IDLE_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R7
  AST_VALID_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !cs_no); // R7
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_no); // R8
endmodule

bind touch_scan_seq touch_scan_seq_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .cs_no(cs_no),
  .mosi_o(mosi_o), .res_valid_o(res_valid_o), .done_o(done_o)
);

// File: tb/touch_scan_seq_tb_top.sv
module touch_scan_seq_tb_top;
  localparam int BIT_NS = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  chan_mask_i = '0;
  logic [127:0] settle_v;
  logic [31:0] ovs_v;
  logic        iref = 1'b0;
  logic        miso_i = 1'b0;
  logic        sclk_o, cs_no, mosi_o, res_valid_o, done_o;
  logic [2:0]  res_chan_o;
  logic [11:0] res_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_empty = 1'b0;
  bit in_scan = 1'b0;
  bit prev_valid = 1'b0;
  bit finished = 1'b0;

  logic [19:0] frm_q[$];
  logic [14:0] res_q[$];

  always #4 clk_i = ~clk_i;

  touch_scan_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .chan_mask_i(chan_mask_i),
    .settle_ns_i(settle_v), .ovs_ratio_i(ovs_v), .int_ref_i(iref),
    .sclk_o(sclk_o), .cs_no(cs_no), .mosi_o(mosi_o), .miso_i(miso_i),
    .res_valid_o(res_valid_o), .res_chan_o(res_chan_o), .res_data_o(res_data_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [11:0] dv(input int ch, input int f, input int seed);
    return 12'((ch * 421 + f * 97 + seed * 131 + 7) % 4096);
  endfunction

  // converter model
  int          edge_n = 0;
  logic [7:0]  cap = '0;
  logic [15:0] rep = '0;

  always @(posedge sclk_o) begin
    if (!cs_no) begin
      cap = {cap[6:0], mosi_o};
      edge_n++;
      if (edge_n == 8) begin
        if (frm_q.size() == 0) begin
          chk(1'b0, "R4 unexpected frame", int'(cap), 0);
          rep = '0;
        end else begin
          logic [19:0] e;
          e = frm_q.pop_front();
          chk(cap == e[19:12], "R1 R2 R3 command byte", int'(cap), int'(e[19:12]));
          rep = {1'b1, e[11:0], 3'b101};
        end
      end
    end
  end

  always @(negedge sclk_o) begin
    if (edge_n >= 8 && edge_n <= 23) miso_i = rep[23 - edge_n];
    if (edge_n >= 24) edge_n = 0;
  end

  always @(posedge cs_no) edge_n = 0;

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (res_valid_o) begin
        if (res_q.size() == 0) begin
          chk(1'b0, "R6 unexpected result", int'({res_chan_o, res_data_o}), 0);
        end else begin
          logic [14:0] r;
          r = res_q.pop_front();
          chk(res_chan_o == r[14:12], "R6 channel order", int'(res_chan_o), int'(r[14:12]));
          chk(res_data_o == r[11:0], "R5 R10 averaged value", int'(res_data_o), int'(r[11:0]));
        end
      end
      if (done_o && !exp_empty)
        chk(prev_valid, "R8 done one cycle after last result", int'(prev_valid), 1);
      if (in_scan && cs_no && !done_o)
        chk(1'b0, "R7 chip select broke during scan", 1, 0);
      prev_valid = res_valid_o;
      if (done_o) in_scan = 1'b0;
    end
  end

  task automatic run_scan(input logic [7:0] mask, input int seed, input bit extra_start);
    for (int ch = 0; ch < 8; ch++) begin
      if (mask[ch]) begin
        int st, ov, n, bits, skip, total, sum;
        logic se;
        st = int'(settle_v[ch*16 +: 16]);
        ov = int'(ovs_v[ch*4 +: 4]);
        n = (ov == 0) ? 1 : ov;
        bits = (st + BIT_NS - 1) / BIT_NS;
        skip = (bits + 23) / 24;
        total = skip + n;
        sum = 0;
        se = (ch == 0) || (ch == 2) || (ch == 6) || (ch == 7);
        for (int f = 0; f < total; f++) begin
          logic last;
          logic [7:0] cmd;
          logic [11:0] v;
          last = (f == total - 1);
          cmd = {1'b1, 3'(ch), 1'b0, se, se & iref & ~last, ~last};
          v = (f < skip) ? 12'hFFF : dv(ch, f, seed);
          if (f >= skip) sum += int'(v);
          frm_q.push_back({cmd, v});
        end
        res_q.push_back({3'(ch), 12'((sum + n - 1) / n)});
      end
    end
    exp_empty = (mask == 8'h00);
    @(negedge clk_i);
    chan_mask_i = mask;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (mask == 8'h00) begin
      chk(done_o == 1'b1, "R8 empty mask done", int'(done_o), 1);
      chk(cs_no == 1'b1, "R8 empty mask keeps cs high", int'(cs_no), 1);
      @(negedge clk_i);
      chk(done_o == 1'b0, "R8 done single cycle", int'(done_o), 0);
      return;
    end
    in_scan = 1'b1;
    if (extra_start) begin
      repeat (150) @(negedge clk_i);
      chan_mask_i = 8'hFF;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chan_mask_i = mask;
    end
    begin
      int t;
      t = 0;
      while (!done_o && t < 100000) begin
        @(negedge clk_i);
        t++;
      end
      chk(done_o == 1'b1, "R8 scan reached done", int'(done_o), 1);
    end
    @(negedge clk_i);
    chk(frm_q.size() == 0, "R4 all frames sent", frm_q.size(), 0);
    chk(res_q.size() == 0, "R6 all results seen", res_q.size(), 0);
    chk(cs_no == 1'b1 && sclk_o == 1'b0, "R7 idle bus after scan", int'({cs_no, sclk_o}), 2);
    frm_q.delete();
    res_q.delete();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      settle_v[i*16 +: 16] = 16'd1000;
      ovs_v[i*4 +: 4] = 4'd1;
    end
    repeat (5) @(negedge clk_i);
    chk(cs_no == 1'b1 && sclk_o == 1'b0, "R7 reset bus idle", int'({cs_no, sclk_o}), 2);
    chk(res_valid_o == 1'b0, "R6 reset no result", int'(res_valid_o), 0);
    chk(done_o == 1'b0, "R8 reset no done", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // default settle (skip 2), sparse mask
    run_scan(8'h26, 1, 1'b0);

    // internal reference, single-ended channels, mixed settle and ratio
    iref = 1'b1;
    settle_v[0*16 +: 16] = 16'd0;    ovs_v[0*4 +: 4] = 4'd4;
    settle_v[2*16 +: 16] = 16'd1000; ovs_v[2*4 +: 4] = 4'd5;
    settle_v[6*16 +: 16] = 16'd800;  ovs_v[6*4 +: 4] = 4'd3;
    settle_v[7*16 +: 16] = 16'd2000; ovs_v[7*4 +: 4] = 4'd2;
    run_scan(8'hC5, 2, 1'b0);

    // full mask, no settling, ratio 0 acts as 1 (R10), ratio 15
    for (int i = 0; i < 8; i++) settle_v[i*16 +: 16] = 16'd0;
    ovs_v = {4'd6, 4'd9, 4'd1, 4'd3, 4'd2, 4'd7, 4'd15, 4'd0};
    run_scan(8'hFF, 3, 1'b0);

    // empty mask
    run_scan(8'h00, 0, 1'b0);

    // start while busy is ignored (R9)
    iref = 1'b0;
    for (int i = 0; i < 8; i++) begin
      settle_v[i*16 +: 16] = 16'd1000;
      ovs_v[i*4 +: 4] = 4'd2;
    end
    run_scan(8'h18, 4, 1'b1);

    // settle boundary: 768 ns -> skip 1, 769 ns -> skip 2 (R4)
    ovs_v[3*4 +: 4] = 4'd1;
    settle_v[3*16 +: 16] = 16'd768;
    run_scan(8'h08, 5, 1'b0);
    settle_v[3*16 +: 16] = 16'd769;
    run_scan(8'h08, 6, 1'b0);

    report();
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, R8 scan never completed actual=0 expected=1");
    report();
  end
endmodule